// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read-side controller of a synchronous flash-style memory port. A 16-bit read configuration register selects between a free-running asynchronous page mode and a clocked burst mode. In burst mode the register also sets the first-access latency, the burst length and whether addresses wrap. An access starts when the active-low address strobe `adv_n` is sampled low: the word address on `addr_in` is captured, along with a snapshot of the configuration. Once the strobe is released, the block counts the programmed number of clocks and then steps a word address out to the storage array. Each presented word is marked with `data_valid`, and the latency gap is marked with `wait_o`.

The sequencer is built around four named states:
- `ST_IDLE` is the rest state.
- `ST_ADDR` holds while the strobe is low.
- `ST_LAT` covers the latency gap.
- `ST_DATA` covers each presented word.

The transitions are:
- IDLE→ADDR, taken when the strobe is low.
- ADDR→ADDR, taken while the strobe stays low (the address is recaptured).
- ADDR→LAT, taken when the strobe is released in burst mode.
- ADDR→DATA, taken when the strobe is released in page mode.
- LAT→DATA, taken when the latency count runs out.
- DATA→DATA, taken to step to the next word.
- DATA→IDLE, taken after the last word.
- LAT→ADDR and DATA→ADDR, taken whenever the strobe is asserted again. This aborts the access.

Status and identifier reads are requested with `status_rd` and always yield a single word. Register writes with reserved encodings are refused field by field and raise a sticky error flag. A separate flag reports the one latency and hold combination that is not supported.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the register selects page mode, `data_valid`, `wait_o`, `cfg_err` and `cfg_unsup` are 0, and a first access behaves as a page read (see R8).
- R2: `addr_in` is captured on each rising edge that samples `adv_n` low. In the cycle after such an edge, `data_valid` and `wait_o` are both 0, whatever access was in progress.
- R3: In burst mode (bit 15 = 0), latency code c (bits 13:11, values 2 to 5) makes the first word valid after the c-th rising edge, counting from and including the first edge that samples `adv_n` high. `wait_o` is 1 in the cycles before that.
- R4: `wait_o` and `data_valid` are never 1 together.
- R5: Burst length bits 2:0 = 001, 010 and 011 give 4, 8 and 16 valid words on consecutive cycles. Both outputs then drop to 0 until the next access.
- R6: With bit 3 = 0 and window length L, word n is at address (start & ~(L-1)) | ((start+n) & (L-1)). With bit 3 = 1, word n is at start+n, modulo 2^AW. In both cases the two low address bits advance by one per word.
- R7: Burst length 111 presents words at start+n on every cycle, with no end, until `adv_n` is asserted.
- R8: With bit 15 = 1, the first word is valid after the first edge that samples `adv_n` high, and `wait_o` stays 0. Four words follow, wrapping inside the aligned 4-word window. The latency, wrap and length fields have no effect.
- R9: When `status_rd` is 1 on the capturing edge, exactly one word at the start address is presented. In burst mode the latency of R3 still applies.
- R10: A write whose latency code is outside 2..5, or whose length code is not 001, 010, 011 or 111, keeps that field's previous value. It still updates the other fields and sets `cfg_err`, which stays 1 until reset.
- R11: A write with any of bits 14, 10 or 7:4 set raises `cfg_err`.
- R12: `cfg_unsup` is 1 exactly while the register holds burst mode, latency code 2, bit 9 = 1 and bit 8 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration register write value |
| adv_n | input | 1 | Active-low address strobe |
| addr_in | input | AW | Start word address |
| status_rd | input | 1 | Single-word status/identifier access request |
| arr_addr | output | AW | Word address to the array, meaningful while data_valid is 1 |
| data_valid | output | 1 | Presented word is valid |
| wait_o | output | 1 | Access in its latency gap, data not valid |
| cfg_err | output | 1 | Sticky flag for a refused or reserved register write |
| cfg_unsup | output | 1 | Unsupported latency/hold combination programmed |

## Verification
The properties assume that `status_rd` and the configuration are steady around the capturing edge. They also assume that a register write never lands inside an access whose timing the bench is predicting. The stimulus therefore writes the register only before raising the strobe. Each access is framed by exactly one low strobe cycle followed by a high strobe. The sweep covers every legal latency code, length code and wrap setting, with start addresses at a window's base, at its middle, near its end and at the top of the address space. In every case the strobe stays high until the access has ended, except in the continuous-burst and abort checks.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_LAT  = 2'd2,
        ST_DATA = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic       page_md;    // 1: asynchronous page mode
        logic [2:0] lat;        // first-access latency code
        logic       hold2;      // two-clock data hold
        logic       wait_early; // WAIT one cycle ahead
        logic       linear;     // 1: no wrap inside the window
        logic [2:0] blen;       // burst length code
    } rd_cfg_t;

    localparam int unsigned CFG_W       = 16;
    localparam int unsigned B_PAGE      = 15;
    localparam int unsigned B_LAT_HI    = 13;
    localparam int unsigned B_LAT_LO    = 11;
    localparam int unsigned B_HOLD      = 9;
    localparam int unsigned B_WEARLY    = 8;
    localparam int unsigned B_LINEAR    = 3;
    localparam logic [15:0] RSVD_MASK   = 16'h44F0;
    localparam logic [2:0]  BL_CONT     = 3'b111;
    localparam logic [2:0]  LAT_RESET   = 3'd3;

    function automatic logic lat_ok(input logic [2:0] c);
        return (c >= 3'd2) && (c <= 3'd5);
    endfunction

    function automatic logic blen_ok(input logic [2:0] c);
        return (c == 3'b001) || (c == 3'b010) || (c == 3'b011) || (c == BL_CONT);
    endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
    import brs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CFG_W-1:0]     wdata,
    output rd_cfg_t              cfg,
    output logic                 err,
    output logic                 unsup
);

    rd_cfg_t     cfg_q;
    logic        err_q;
    logic [2:0]  w_lat;
    logic [2:0]  w_blen;
    logic        w_bad;

    always_comb begin
        w_lat  = wdata[B_LAT_HI:B_LAT_LO];
        w_blen = wdata[2:0];
        w_bad  = !lat_ok(w_lat) || !blen_ok(w_blen) || ((wdata & RSVD_MASK) != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.page_md    <= 1'b1;
            cfg_q.lat        <= LAT_RESET;
            cfg_q.hold2      <= 1'b0;
            cfg_q.wait_early <= 1'b0;
            cfg_q.linear     <= 1'b1;
            cfg_q.blen       <= BL_CONT;
            err_q            <= 1'b0;
        end else if (we) begin
            cfg_q.page_md    <= wdata[B_PAGE];
            cfg_q.hold2      <= wdata[B_HOLD];
            cfg_q.wait_early <= wdata[B_WEARLY];
            cfg_q.linear     <= wdata[B_LINEAR];
            if (lat_ok(w_lat)) begin
                cfg_q.lat <= w_lat;
            end
            if (blen_ok(w_blen)) begin
                cfg_q.blen <= w_blen;
            end
            if (w_bad) begin
                err_q <= 1'b1;
            end
        end
    end

    assign cfg   = cfg_q;
    assign err   = err_q;
    assign unsup = !cfg_q.page_md && (cfg_q.lat == 3'd2) && cfg_q.hold2 && cfg_q.wait_early;

endmodule

// File: rtl/brs_fsm.sv
module brs_fsm
    import brs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv_n,
    input  logic [2:0]  lat_code,
    input  logic        page_md,
    input  logic        last_word,
    output logic        load,
    output logic        step,
    output logic        data_valid,
    output logic        wait_o
);

    seq_state_t state_q, state_d;
    logic [2:0] cnt_q;
    logic [2:0] lat_s;
    logic       fast_s;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!adv_n) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (!adv_n)      state_d = ST_ADDR;
                else if (fast_s) state_d = ST_DATA;
                else             state_d = ST_LAT;
            end
            ST_LAT: begin
                if (!adv_n)            state_d = ST_ADDR;
                else if (cnt_q == '0)  state_d = ST_DATA;
            end
            ST_DATA: begin
                if (!adv_n)         state_d = ST_ADDR;
                else if (last_word) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // latency counter and per-access snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lat_s  <= LAT_RESET;
            fast_s <= 1'b1;
        end else begin
            if (!adv_n) begin
                lat_s  <= lat_code;
                fast_s <= page_md;
            end
            if (state_q == ST_ADDR && adv_n) begin
                cnt_q <= lat_s - 3'd2;
            end else if (state_q == ST_LAT && cnt_q != '0) begin
                cnt_q <= cnt_q - 3'd1;
            end
        end
    end

    // outputs
    always_comb begin
        load       = !adv_n;
        step       = (state_q == ST_DATA) && adv_n && !last_word;
        data_valid = (state_q == ST_DATA);
        wait_o     = (state_q == ST_LAT);
    end

endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen
    import brs_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_in,
    input  logic          single,
    input  rd_cfg_t       cfg,
    output logic [AW-1:0] arr_addr,
    output logic          last_word
);

    logic [AW-1:0] start_q, n_q, mask_q;
    logic          wrap_q, cont_q;
    logic [AW-1:0] mask_d;
    logic          wrap_d, cont_d;
    logic [AW-1:0] lin_addr;

    // window selection for the access being captured
    always_comb begin
        mask_d = AW'(3);
        wrap_d = 1'b0;
        cont_d = 1'b0;
        if (single) begin
            mask_d = '0;
        end else if (cfg.page_md) begin
            mask_d = AW'(3);
            wrap_d = 1'b1;
        end else begin
            unique case (cfg.blen)
                3'b001:  mask_d = AW'(3);
                3'b010:  mask_d = AW'(7);
                3'b011:  mask_d = AW'(15);
                default: mask_d = '0;
            endcase
            cont_d = (cfg.blen == BL_CONT);
            wrap_d = !cfg.linear && !cont_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            n_q     <= '0;
            mask_q  <= '0;
            wrap_q  <= 1'b0;
            cont_q  <= 1'b0;
        end else if (load) begin
            start_q <= addr_in;
            n_q     <= '0;
            mask_q  <= mask_d;
            wrap_q  <= wrap_d;
            cont_q  <= cont_d;
        end else if (step) begin
            n_q <= n_q + AW'(1);
        end
    end

    assign lin_addr  = start_q + n_q;
    assign arr_addr  = wrap_q ? ((start_q & ~mask_q) | (lin_addr & mask_q)) : lin_addr;
    assign last_word = !cont_q && (n_q == mask_q);

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import brs_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_wdata,
    input  logic          adv_n,
    input  logic [AW-1:0] addr_in,
    input  logic          status_rd,
    output logic [AW-1:0] arr_addr,
    output logic          data_valid,
    output logic          wait_o,
    output logic          cfg_err,
    output logic          cfg_unsup
);

    rd_cfg_t cfg;
    logic    load, step, last_word;

    brs_cfg_reg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .err   (cfg_err),
        .unsup (cfg_unsup)
    );

    brs_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_n      (adv_n),
        .lat_code   (cfg.lat),
        .page_md    (cfg.page_md),
        .last_word  (last_word),
        .load       (load),
        .step       (step),
        .data_valid (data_valid),
        .wait_o     (wait_o)
    );

    brs_addr_gen #(.AW(AW)) i_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .addr_in   (addr_in),
        .single    (status_rd),
        .cfg       (cfg),
        .arr_addr  (arr_addr),
        .last_word (last_word)
    );

endmodule

// File: rtl/brs_checker.sv
module brs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       adv_n,
    input logic       status_rd,
    input logic       data_valid,
    input logic       wait_o,
    input logic       cfg_err,
    input logic [1:0] addr_lo
);

    logic single_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      single_q <= 1'b0;
        else if (!adv_n) single_q <= status_rd;
    end

    AST_WAIT_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> !data_valid); // R4

    AST_ADV_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_n |=> (!data_valid && !wait_o)); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R10

    AST_SINGLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (single_q && data_valid && adv_n) |=> !data_valid); // R9

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid)) |-> (addr_lo == $past(addr_lo) + 2'd1)); // R6

endmodule

bind burst_read_seq brs_checker i_brs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_n      (adv_n),
    .status_rd  (status_rd),
    .data_valid (data_valid),
    .wait_o     (wait_o),
    .cfg_err    (cfg_err),
    .addr_lo    (arr_addr[1:0])
);

// File: tb/test_burst_read_seq.sv
module test_burst_read_seq;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          status_rd = 1'b0;
    logic [AW-1:0] arr_addr;
    logic          data_valid, wait_o, cfg_err, cfg_unsup;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    burst_read_seq #(.AW(AW)) i_burst_read_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .adv_n(adv_n), .addr_in(addr_in), .status_rd(status_rd),
        .arr_addr(arr_addr), .data_valid(data_valid), .wait_o(wait_o),
        .cfg_err(cfg_err), .cfg_unsup(cfg_unsup)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mkcfg(input bit page, input int lat, input bit hold,
                                          input bit early, input bit lin, input int bl);
        logic [15:0] w;
        w = '0;
        w[15] = page;
        w[13:11] = 3'(lat);
        w[9] = hold;
        w[8] = early;
        w[3] = lin;
        w[2:0] = 3'(bl);
        return w;
    endfunction

    function automatic int exp_addr(input int s, input int n, input int len, input bit wrap);
        int m;
        if (wrap) begin
            m = len - 1;
            return ((s & ~m) | ((s + n) & m)) & 16'hFFFF;
        end
        return (s + n) & 16'hFFFF;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        adv_n = 1'b1;
        cfg_we = 1'b0;
        status_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // lat: edges until first word; len 0 = continuous (20 words then abort)
    task automatic burst(input int lat, input int len, input bit wrap, input int start, input string tag);
        int total;
        @(negedge clk);
        adv_n = 1'b0;
        addr_in = AW'(start);
        @(negedge clk);
        adv_n = 1'b1;
        total = (len == 0) ? lat + 19 : lat + len;
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            chk(!(wait_o && data_valid), "R4 exclusive", {wait_o, data_valid}, 2'b00);
            if (k < lat) begin
                chk(wait_o == 1'b1 && data_valid == 1'b0, {"R3 latency gap ", tag},
                    {wait_o, data_valid}, 2'b10);
            end else if (len == 0 || (k - lat) < len) begin
                chk(data_valid == 1'b1 && wait_o == 1'b0, {"R3 valid ", tag},
                    {wait_o, data_valid}, 2'b01);
                chk(int'(arr_addr) == exp_addr(start, k - lat, len, wrap), {"R6 address ", tag},
                    int'(arr_addr), exp_addr(start, k - lat, len, wrap));
            end else begin
                chk(data_valid == 1'b0 && wait_o == 1'b0, {"R5 end ", tag},
                    {wait_o, data_valid}, 2'b00);
            end
        end
        if (len == 0) begin
            adv_n = 1'b0;
            addr_in = '0;
            @(negedge clk);
            chk(data_valid == 1'b0 && wait_o == 1'b0, {"R2 abort ", tag},
                {wait_o, data_valid}, 2'b00);
            adv_n = 1'b1;
            repeat (8) @(negedge clk);
        end
    endtask

    initial begin
        int starts[4];
        starts[0] = 0; starts[1] = 5; starts[2] = 13; starts[3] = 16'hFFFE;

        do_reset();
        chk(!data_valid && !wait_o, "R1 idle outputs", {wait_o, data_valid}, 0);
        chk(!cfg_err && !cfg_unsup, "R1 flags", {cfg_err, cfg_unsup}, 0);
        burst(1, 4, 1'b1, 6, "R1 default page");

        // R5 R6 R3 sweep over legal length, wrap and latency codes
        for (int bl = 1; bl <= 3; bl++) begin
            for (int lin = 0; lin <= 1; lin++) begin
                for (int lat = 2; lat <= 5; lat++) begin
                    wr(mkcfg(1'b0, lat, 1'b0, 1'b0, 1'(lin), bl));
                    for (int si = 0; si < 4; si++) begin
                        burst(lat, 4 << (bl - 1), !lin, starts[si],
                              $sformatf("R5 bl%0d lin%0d lat%0d s%0h", bl, lin, lat, starts[si]));
                    end
                end
            end
        end
        chk(!cfg_err, "R10 legal writes leave flag clear", cfg_err, 0);

        // R7 continuous, wrap bit irrelevant
        wr(mkcfg(1'b0, 3, 1'b0, 1'b0, 1'b1, 7));
        burst(3, 0, 1'b0, 16'hFFF5, "R7 continuous lin");
        wr(mkcfg(1'b0, 2, 1'b0, 1'b0, 1'b0, 7));
        burst(2, 0, 1'b0, 9, "R7 continuous wrapbit0");

        // R8 page mode ignores latency, length and wrap fields
        wr(mkcfg(1'b1, 5, 1'b0, 1'b0, 1'b1, 3));
        burst(1, 4, 1'b1, 16'h0123, "R8 page");
        wr(mkcfg(1'b1, 2, 1'b0, 1'b0, 1'b0, 7));
        burst(1, 4, 1'b1, 16'h0FFF, "R8 page b");

        // R9 single-word status/ID reads
        status_rd = 1'b1;
        wr(mkcfg(1'b0, 4, 1'b0, 1'b0, 1'b1, 3));
        burst(4, 1, 1'b0, 16'h0042, "R9 single sync");
        wr(mkcfg(1'b0, 2, 1'b0, 1'b0, 1'b1, 7));
        burst(2, 1, 1'b0, 16'h0077, "R9 single sync cont");
        wr(mkcfg(1'b1, 2, 1'b0, 1'b0, 1'b1, 7));
        burst(1, 1, 1'b0, 16'h0031, "R9 single page");
        status_rd = 1'b0;

        // R12 unsupported combination
        wr(mkcfg(1'b0, 2, 1'b1, 1'b1, 1'b1, 1));
        chk(cfg_unsup == 1'b1, "R12 unsupported set", cfg_unsup, 1);
        wr(mkcfg(1'b1, 2, 1'b1, 1'b1, 1'b1, 1));
        chk(cfg_unsup == 1'b0, "R12 page mode clear", cfg_unsup, 0);
        wr(mkcfg(1'b0, 3, 1'b1, 1'b1, 1'b1, 1));
        chk(cfg_unsup == 1'b0, "R12 latency 3 clear", cfg_unsup, 0);
        wr(mkcfg(1'b0, 2, 1'b0, 1'b1, 1'b1, 1));
        chk(cfg_unsup == 1'b0, "R12 no hold clear", cfg_unsup, 0);

        // R10 reserved latency / length codes
        do_reset();
        wr(mkcfg(1'b0, 3, 1'b0, 1'b0, 1'b1, 2));
        chk(!cfg_err, "R10 legal write", cfg_err, 0);
        wr(mkcfg(1'b0, 7, 1'b0, 1'b0, 1'b1, 3));
        chk(cfg_err == 1'b1, "R10 reserved latency flag", cfg_err, 1);
        burst(3, 16, 1'b0, 16'h0100, "R10 latency kept");
        wr(mkcfg(1'b0, 4, 1'b0, 1'b0, 1'b0, 5));
        burst(4, 16, 1'b1, 16'h0107, "R10 length kept");
        chk(cfg_err == 1'b1, "R10 sticky", cfg_err, 1);
        wr(mkcfg(1'b0, 1, 1'b0, 1'b0, 1'b1, 0));
        burst(4, 16, 1'b0, 16'h0200, "R10 both kept");

        // R11 reserved bits
        do_reset();
        wr(mkcfg(1'b0, 3, 1'b0, 1'b0, 1'b1, 1) | 16'h4000);
        chk(cfg_err == 1'b1, "R11 bit14", cfg_err, 1);
        do_reset();
        wr(mkcfg(1'b0, 3, 1'b0, 1'b0, 1'b1, 1) | 16'h0400);
        chk(cfg_err == 1'b1, "R11 bit10", cfg_err, 1);
        do_reset();
        wr(mkcfg(1'b0, 3, 1'b0, 1'b0, 1'b1, 1) | 16'h0020);
        chk(cfg_err == 1'b1, "R11 bit5", cfg_err, 1);

        // R2 abort in the latency gap, then recapture
        do_reset();
        wr(mkcfg(1'b0, 5, 1'b0, 1'b0, 1'b1, 1));
        @(negedge clk);
        adv_n = 1'b0;
        addr_in = 16'h0AAA;
        @(negedge clk);
        adv_n = 1'b1;
        repeat (2) @(negedge clk);
        adv_n = 1'b0;
        @(negedge clk);
        chk(!data_valid && !wait_o, "R2 abort in gap", {wait_o, data_valid}, 0);
        adv_n = 1'b1;
        repeat (8) @(negedge clk);
        burst(5, 4, 1'b0, 16'h0AAA, "R2 after abort");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule